// File: doc/BRIEF.md
# Transmit Endpoint Priming Buffer Manager

This block gets the transmit endpoints of a USB device controller ready before the host asks them for data. A prime request on an endpoint makes the block read that endpoint's transfer descriptor from a fixed queue-head slot in memory. The descriptor is kept in a per-endpoint context until the transfer is finished. The block then preloads the first bytes of the packet into that endpoint's share of a common buffer. When the share is full, or the descriptor has no bytes left, the endpoint's primed status bit goes high. From then on an IN token gets an immediate acknowledge instead of a NAK.

The packet serializer pops bytes from a channel. While it does so, the block keeps fetching the rest of the transfer behind the bytes already taken, so the channel never needs to hold more than its fixed depth. A flush throws away everything queued for an endpoint. All memory reads go through one request/grant/valid port, and endpoints that want it are served in round-robin order.

Top module: `tpm_prime_mgr`

## Requirements
- R1: After reset, `ep_primed`, `ep_refill`, `mem_req`, `in_ack` and `in_nak` are all low.
- R2: A prime request on endpoint e reads the descriptor at address QH_BASE + e*QH_STRIDE. In the returned word, bits [15:0] hold the buffer start address and bits [31:16] hold the byte count.
- R3: After the descriptor arrives, bytes are read from consecutive addresses starting at the buffer address, one per memory read, with the byte in `mem_rdata[7:0]`. Reading stops when the channel holds CH_DEPTH bytes or the count is used up. At that point the endpoint's bit in `ep_primed` is set.
- R4: An IN token (`in_token` with `in_ep`) gives `in_ack` on the next cycle if that endpoint is primed, and `in_nak` otherwise. The two are never high together.
- R5: When primed, popping a channel returns the transfer's bytes in address order, including across refills. Each channel is independent of the others.
- R6: `ep_refill[e]` is high while e is primed, bytes remain in its transfer and its channel holds fewer than WMARK bytes. The block then fetches more bytes for it.
- R7: Popping the last byte of a transfer clears the endpoint's primed bit and releases its descriptor.
- R8: A flush on endpoint e does all of the following:
  - empties e's channel;
  - clears its primed bit, its descriptor and any pending prime;
  - wins over a prime request on e in the same cycle;
  - causes the response to a read already issued for e to be dropped.
- R9: `mem_req` stays high with `mem_addr` unchanged until `mem_gnt`. No new request is made while a granted read still awaits `mem_rvalid`.
- R10: When several endpoints are pending, descriptor fetches are served in round-robin order of endpoint index.
- R11: A prime request on an endpoint that already holds a descriptor, or already has a prime pending, is ignored. Its transfer continues without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prime_req | input | NUM_EP | One-cycle prime pulse per endpoint |
| flush_req | input | NUM_EP | One-cycle flush pulse per endpoint |
| ep_primed | output | NUM_EP | Primed status per endpoint |
| ep_refill | output | NUM_EP | Channel below watermark with data outstanding |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (descriptor or data byte) |
| in_token | input | 1 | IN token received |
| in_ep | input | EP_W | Endpoint addressed by the token |
| in_ack | output | 1 | Token answered with data |
| in_nak | output | 1 | Token answered with NAK |
| tx_pop | input | 1 | Serializer takes one byte |
| tx_ep | input | EP_W | Channel the serializer reads |
| tx_data | output | 8 | Head byte of the selected channel |
| tx_empty | output | 1 | Selected channel has nothing to give |

## Verification
Transfers of 1, 3, 8, 13 and 20 bytes are primed one endpoint at a time. This separates three cases:
- a transfer shorter than the channel;
- a transfer exactly as deep as the channel;
- a transfer that depends on refill, including one whose addresses cross a 256-byte boundary.

Stalling the grant while the serializer drains a channel shows the watermark raising a refill request. A second prime in the middle of that transfer shows it does not restart. Flushes are applied in three situations, each of which a wrong priority or a missed cancel would reveal:
- after priming completes;
- in the same cycle as a prime;
- while a descriptor read is outstanding.

Four endpoints primed at once show whether descriptor reads rotate in index order.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 8;
    localparam int MEM_W  = 32;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [ADDR_W-1:0] addr;
    } desc_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } fetch_st_t;

    typedef enum logic {
        OP_DESC = 1'b0,
        OP_DATA = 1'b1
    } fetch_op_t;

    function automatic logic [ADDR_W-1:0] qh_slot_addr(
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-1:0] stride,
        input int                idx
    );
        return base + ADDR_W'(idx) * stride;
    endfunction
endpackage

// File: rtl/tpm_rr_arb.sv
module tpm_rr_arb #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    input  logic             adv,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    logic [IDX_W-1:0] last;

    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(last) + k) % N;
            if (!any && req[c]) begin
                any = 1'b1;
                idx = IDX_W'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last <= IDX_W'(N - 1);
        end else if (adv && any) begin
            last <= idx;
        end
    end
endmodule

// File: rtl/tpm_vbuf.sv
module tpm_vbuf #(
    parameter int N     = 4,
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    parameter int CH_W  = 2,
    parameter int LVL_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N-1:0]              clr,
    input  logic                      wr_en,
    input  logic [CH_W-1:0]           wr_ch,
    input  logic [DW-1:0]             wr_data,
    input  logic                      rd_en,
    input  logic [CH_W-1:0]           rd_ch,
    output logic [DW-1:0]             rd_data,
    output logic [N-1:0][LVL_W-1:0]   level
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int MW    = $clog2(N * DEPTH);

    logic [DW-1:0]    mem  [N*DEPTH];
    logic [PTR_W-1:0] wptr [N];
    logic [PTR_W-1:0] rptr [N];
    logic [LVL_W-1:0] lvl  [N];
    logic [MW-1:0]    widx;
    logic [MW-1:0]    ridx;

    for (genvar ch = 0; ch < N; ch++) begin : g_chan
        logic we;
        logic re;
        assign we = wr_en && (wr_ch == CH_W'(ch)) && !clr[ch] && (lvl[ch] != LVL_W'(DEPTH));
        assign re = rd_en && (rd_ch == CH_W'(ch)) && !clr[ch] && (lvl[ch] != '0);

        always_ff @(posedge clk) begin
            if (rst || clr[ch]) begin
                wptr[ch] <= '0;
                rptr[ch] <= '0;
                lvl[ch]  <= '0;
            end else begin
                if (we) wptr[ch] <= wptr[ch] + 1'b1;
                if (re) rptr[ch] <= rptr[ch] + 1'b1;
                case ({we, re})
                    2'b10:   lvl[ch] <= lvl[ch] + 1'b1;
                    2'b01:   lvl[ch] <= lvl[ch] - 1'b1;
                    default: lvl[ch] <= lvl[ch];
                endcase
            end
        end

        assign level[ch] = lvl[ch];
    end

    assign widx    = MW'(int'(wr_ch) * DEPTH + int'(wptr[wr_ch]));
    assign ridx    = MW'(int'(rd_ch) * DEPTH + int'(rptr[rd_ch]));
    assign rd_data = mem[ridx];

    always_ff @(posedge clk) begin
        if (wr_en) mem[widx] <= wr_data;
    end
endmodule

// File: rtl/tpm_prime_mgr.sv
module tpm_prime_mgr
    import tpm_pkg::*;
#(
    parameter int                NUM_EP    = 4,
    parameter int                EP_W      = $clog2(NUM_EP),
    parameter int                CH_DEPTH  = 8,
    parameter int                WMARK     = 4,
    parameter logic [ADDR_W-1:0] QH_BASE   = 16'hF000,
    parameter logic [ADDR_W-1:0] QH_STRIDE = 16'h0010
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EP-1:0]  prime_req,
    input  logic [NUM_EP-1:0]  flush_req,
    output logic [NUM_EP-1:0]  ep_primed,
    output logic [NUM_EP-1:0]  ep_refill,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_gnt,
    input  logic               mem_rvalid,
    input  logic [MEM_W-1:0]   mem_rdata,
    input  logic               in_token,
    input  logic [EP_W-1:0]    in_ep,
    output logic               in_ack,
    output logic               in_nak,
    input  logic               tx_pop,
    input  logic [EP_W-1:0]    tx_ep,
    output logic [DATA_W-1:0]  tx_data,
    output logic               tx_empty
);
    localparam int LVL_W = $clog2(CH_DEPTH + 1);

    fetch_st_t                 st;
    fetch_op_t                 cur_op;
    logic [EP_W-1:0]           cur_ep;
    logic [ADDR_W-1:0]         cur_addr;
    logic                      cancel;
    logic [NUM_EP-1:0]         pend;
    logic [NUM_EP-1:0]         dvalid;
    logic [NUM_EP-1:0]         primed;
    logic [ADDR_W-1:0]         buf_addr [NUM_EP];
    logic [CNT_W-1:0]          rem      [NUM_EP];
    logic [NUM_EP-1:0][LVL_W-1:0] lvl;
    logic [NUM_EP-1:0]         want;
    logic [NUM_EP-1:0]         inflight_desc;
    logic [EP_W-1:0]           arb_idx;
    logic                      arb_any;
    logic                      arb_adv;
    logic                      resp_ok;
    logic                      wr_en;
    logic                      pop_fire;
    desc_t                     rdesc;

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        logic has_bytes;
        logic below_wm;
        assign has_bytes = (rem[e] != '0);
        assign below_wm  = (lvl[e] < LVL_W'(WMARK));
        assign want[e] = pend[e] |
                         (dvalid[e] && has_bytes && (lvl[e] != LVL_W'(CH_DEPTH)) &&
                          (!primed[e] || below_wm));
        assign ep_refill[e] = dvalid[e] && primed[e] && has_bytes && below_wm;
        assign inflight_desc[e] = (st != ST_IDLE) && (cur_op == OP_DESC) &&
                                  (cur_ep == EP_W'(e));
    end

    assign arb_adv   = (st == ST_IDLE);
    assign rdesc     = desc_t'(mem_rdata);
    assign resp_ok   = (st == ST_WAIT) && mem_rvalid && !cancel && !flush_req[cur_ep];
    assign wr_en     = resp_ok && (cur_op == OP_DATA);
    assign pop_fire  = tx_pop && primed[tx_ep] && (lvl[tx_ep] != '0) && !flush_req[tx_ep];
    assign tx_empty  = !primed[tx_ep] || (lvl[tx_ep] == '0);
    assign mem_req   = (st == ST_REQ);
    assign mem_addr  = cur_addr;
    assign ep_primed = primed;

    tpm_rr_arb #(.N(NUM_EP), .IDX_W(EP_W)) u_arb (
        .clk (clk),
        .rst (rst),
        .req (want),
        .adv (arb_adv),
        .idx (arb_idx),
        .any (arb_any)
    );

    tpm_vbuf #(
        .N(NUM_EP), .DEPTH(CH_DEPTH), .DW(DATA_W), .CH_W(EP_W), .LVL_W(LVL_W)
    ) u_vbuf (
        .clk     (clk),
        .rst     (rst),
        .clr     (flush_req),
        .wr_en   (wr_en),
        .wr_ch   (cur_ep),
        .wr_data (mem_rdata[DATA_W-1:0]),
        .rd_en   (pop_fire),
        .rd_ch   (tx_ep),
        .rd_data (tx_data),
        .level   (lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cur_op   <= OP_DESC;
            cur_ep   <= '0;
            cur_addr <= '0;
            cancel   <= 1'b0;
            pend     <= '0;
            dvalid   <= '0;
            primed   <= '0;
            in_ack   <= 1'b0;
            in_nak   <= 1'b0;
            for (int e = 0; e < NUM_EP; e++) begin
                buf_addr[e] <= '0;
                rem[e]      <= '0;
            end
        end else begin
            in_ack <= in_token && primed[in_ep];
            in_nak <= in_token && !primed[in_ep];

            case (st)
                ST_IDLE: begin
                    if (arb_any) begin
                        st     <= ST_REQ;
                        cur_ep <= arb_idx;
                        cancel <= flush_req[arb_idx];
                        if (pend[arb_idx]) begin
                            cur_op        <= OP_DESC;
                            cur_addr      <= qh_slot_addr(QH_BASE, QH_STRIDE, int'(arb_idx));
                            pend[arb_idx] <= 1'b0;
                        end else begin
                            cur_op   <= OP_DATA;
                            cur_addr <= buf_addr[arb_idx];
                        end
                    end
                end
                ST_REQ: begin
                    if (flush_req[cur_ep]) cancel <= 1'b1;
                    if (mem_gnt) st <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (flush_req[cur_ep]) cancel <= 1'b1;
                    if (mem_rvalid) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase

            if (resp_ok) begin
                if (cur_op == OP_DESC) begin
                    dvalid[cur_ep]   <= 1'b1;
                    buf_addr[cur_ep] <= rdesc.addr;
                    rem[cur_ep]      <= rdesc.count;
                end else begin
                    buf_addr[cur_ep] <= buf_addr[cur_ep] + 1'b1;
                    rem[cur_ep]      <= rem[cur_ep] - 1'b1;
                end
            end

            for (int e = 0; e < NUM_EP; e++) begin
                if (dvalid[e] && !primed[e] &&
                    ((lvl[e] == LVL_W'(CH_DEPTH)) || (rem[e] == '0)))
                    primed[e] <= 1'b1;
            end

            if (pop_fire && (lvl[tx_ep] == LVL_W'(1)) && (rem[tx_ep] == '0)) begin
                dvalid[tx_ep] <= 1'b0;
                primed[tx_ep] <= 1'b0;
            end

            for (int e = 0; e < NUM_EP; e++) begin
                if (prime_req[e] && !dvalid[e] && !pend[e] && !inflight_desc[e])
                    pend[e] <= 1'b1;
            end

            for (int e = 0; e < NUM_EP; e++) begin
                if (flush_req[e]) begin
                    pend[e]   <= 1'b0;
                    dvalid[e] <= 1'b0;
                    primed[e] <= 1'b0;
                    rem[e]    <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/tpm_prime_chk.sv
module tpm_prime_chk #(
    parameter int NUM_EP = 4,
    parameter int EP_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_EP-1:0] flush_req,
    input logic [NUM_EP-1:0] ep_primed,
    input logic [NUM_EP-1:0] ep_refill,
    input logic              mem_req,
    input logic [15:0]       mem_addr,
    input logic              mem_gnt,
    input logic              mem_rvalid,
    input logic              in_token,
    input logic [EP_W-1:0]   in_ep,
    input logic              in_ack,
    input logic              in_nak
);
    logic outst;

    always_ff @(posedge clk) begin
        if (rst) outst <= 1'b0;
        else if (mem_req && mem_gnt) outst <= 1'b1;
        else if (mem_rvalid) outst <= 1'b0;
    end

    assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (rst)
        outst |-> !mem_req);

    assert_nak_unprimed_R4: assert property (@(posedge clk) disable iff (rst)
        (in_token && !ep_primed[in_ep]) |=> (in_nak && !in_ack));

    assert_ack_primed_R4: assert property (@(posedge clk) disable iff (rst)
        (in_token && ep_primed[in_ep]) |=> (in_ack && !in_nak));

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (|flush_req) |=> ((ep_primed & $past(flush_req)) == '0));

    assert_refill_needs_prime_R6: assert property (@(posedge clk) disable iff (rst)
        (ep_refill & ~ep_primed) == '0);
endmodule

bind tpm_prime_mgr tpm_prime_chk #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush_req  (flush_req),
    .ep_primed  (ep_primed),
    .ep_refill  (ep_refill),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .in_token   (in_token),
    .in_ep      (in_ep),
    .in_ack     (in_ack),
    .in_nak     (in_nak)
);

// File: tb/tpm_prime_mgr_bench.sv
module tpm_prime_mgr_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_EP = 4;
    localparam int EP_W = 2;
    localparam logic [15:0] QHB = 16'hF000;

    // {endpoint[31:24], byte count[23:16], buffer address[15:0]}
    localparam logic [31:0] VEC [5] = '{
        {8'd0, 8'd3,  16'h0100},
        {8'd1, 8'd20, 16'h0230},
        {8'd2, 8'd8,  16'h0340},
        {8'd3, 8'd1,  16'h04F0},
        {8'd0, 8'd13, 16'h05FE}
    };

    logic clk = 1'b0;
    logic rst;
    logic [NUM_EP-1:0] prime_req, flush_req, ep_primed, ep_refill;
    logic mem_req, mem_gnt, mem_rvalid;
    logic [15:0] mem_addr;
    logic [31:0] mem_rdata;
    logic in_token, in_ack, in_nak, tx_pop, tx_empty;
    logic [EP_W-1:0] in_ep, tx_ep;
    logic [7:0] tx_data;

    logic gnt_en;
    logic [15:0] dbase [NUM_EP];
    logic [15:0] dcount [NUM_EP];
    logic [15:0] qh_log [64];
    int qn;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tpm_prime_mgr u_tpm_prime_mgr (
        .clk(clk), .rst(rst), .prime_req(prime_req), .flush_req(flush_req),
        .ep_primed(ep_primed), .ep_refill(ep_refill), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .in_token(in_token), .in_ep(in_ep),
        .in_ack(in_ack), .in_nak(in_nak), .tx_pop(tx_pop), .tx_ep(tx_ep),
        .tx_data(tx_data), .tx_empty(tx_empty)
    );

    assign mem_gnt = gnt_en;

    function automatic logic [31:0] mem_word(input logic [15:0] a);
        int e;
        if (a >= QHB) begin
            e = int'(a - QHB) / 16;
            return {dcount[e], dbase[e]};
        end
        return {24'h0, a[7:0] ^ 8'h5A};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            qn         <= 0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mem_req && mem_gnt) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem_word(mem_addr);
                if (mem_addr >= QHB) begin
                    qh_log[qn % 64] <= mem_addr;
                    qn <= qn + 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic prime(input int e);
        prime_req = NUM_EP'(1) << e;
        @(negedge clk);
        prime_req = '0;
    endtask

    task automatic flush(input logic [NUM_EP-1:0] m);
        flush_req = m;
        @(negedge clk);
        flush_req = '0;
    endtask

    task automatic wait_primed(input int e);
        for (int n = 0; n < 400 && !ep_primed[e]; n++) @(negedge clk);
    endtask

    task automatic token(input int e, output logic ack, output logic nak);
        in_token = 1'b1;
        in_ep = EP_W'(e);
        @(negedge clk);
        in_token = 1'b0;
        ack = in_ack;
        nak = in_nak;
    endtask

    task automatic pop_check(input int e, input logic [15:0] a, input string tag);
        tx_ep = EP_W'(e);
        #1;
        for (int n = 0; n < 400 && tx_empty; n++) begin
            @(negedge clk);
            #1;
        end
        chk(tag, tx_data, a[7:0] ^ 8'h5A);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack, nak;
        int qs;
        rst = 1'b1; prime_req = '0; flush_req = '0; in_token = 1'b0; in_ep = '0;
        tx_pop = 1'b0; tx_ep = '0; gnt_en = 1'b1;
        for (int e = 0; e < NUM_EP; e++) begin dbase[e] = '0; dcount[e] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 primed", ep_primed, 0);
        chk("R1 refill", ep_refill, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 in_ack", in_ack, 0);
        token(0, ack, nak);
        chk("R4 nak when unprimed", {ack, nak}, 2'b01);

        // table walk: R2 R3 R4 R5 R7
        for (int v = 0; v < 5; v++) begin
            int e;
            int cnt;
            logic [15:0] base;
            e = int'(VEC[v][31:24]);
            cnt = int'(VEC[v][23:16]);
            base = VEC[v][15:0];
            dbase[e] = base;
            dcount[e] = 16'(cnt);
            qs = qn;
            prime(e);
            wait_primed(e);
            chk("R3 primed set", ep_primed[e], 1);
            chk("R2 descriptor address", qh_log[qs % 64], QHB + 16'(e * 16));
            token(e, ack, nak);
            chk("R4 ack when primed", {ack, nak}, 2'b10);
            for (int i = 0; i < cnt; i++) pop_check(e, base + 16'(i), "R5 data order");
            chk("R7 primed cleared", ep_primed[e], 0);
            token(e, ack, nak);
            chk("R7 nak after completion", {ack, nak}, 2'b01);
        end

        // R6 refill watermark, R11 re-prime ignored
        dbase[1] = 16'h0600; dcount[1] = 16'd20;
        prime(1);
        wait_primed(1);
        chk("R6 refill low when full", ep_refill[1], 0);
        gnt_en = 1'b0;
        for (int i = 0; i < 5; i++) pop_check(1, 16'h0600 + 16'(i), "R5 data before refill");
        chk("R6 refill high below watermark", ep_refill[1], 1);
        gnt_en = 1'b1;
        prime(1);
        for (int i = 5; i < 20; i++) pop_check(1, 16'h0600 + 16'(i), "R11 transfer not restarted");
        chk("R7 primed cleared after refill", ep_primed[1], 0);

        // R8 flush after priming
        dbase[2] = 16'h0700; dcount[2] = 16'd20;
        prime(2);
        wait_primed(2);
        flush(4'b0100);
        chk("R8 flush clears primed", ep_primed[2], 0);
        tx_ep = 2'd2;
        #1;
        chk("R8 flush empties channel", tx_empty, 1);
        token(2, ack, nak);
        chk("R8 nak after flush", {ack, nak}, 2'b01);
        prime(2);
        wait_primed(2);
        pop_check(2, 16'h0700, "R8 restart from buffer start");
        flush(4'b0100);

        // R8 prime and flush in the same cycle
        qs = qn;
        prime_req = 4'b1000; flush_req = 4'b1000;
        @(negedge clk);
        prime_req = '0; flush_req = '0;
        repeat (40) @(negedge clk);
        chk("R8 flush beats prime", ep_primed[3], 0);
        chk("R8 no fetch after flush", qn - qs, 0);

        // R9 stalled request, R8 flush while read outstanding
        dbase[0] = 16'h0800; dcount[0] = 16'd5;
        gnt_en = 1'b0;
        prime(0);
        for (int n = 0; n < 50 && !mem_req; n++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9 request held", mem_req, 1);
        chk("R9 address stable", mem_addr, QHB);
        flush(4'b0001);
        gnt_en = 1'b1;
        repeat (40) @(negedge clk);
        chk("R8 outstanding read dropped", ep_primed[0], 0);

        // R10 round robin
        for (int e = 0; e < NUM_EP; e++) begin
            dbase[e] = 16'h0900 + 16'(e * 32);
            dcount[e] = 16'd2;
        end
        qs = qn;
        prime_req = 4'b1111;
        @(negedge clk);
        prime_req = '0;
        for (int n = 0; n < 400 && ep_primed != 4'b1111; n++) @(negedge clk);
        chk("R10 all primed", ep_primed, 4'b1111);
        chk("R10 four descriptor reads", qn - qs, 4);
        for (int i = 0; i < 3; i++) begin
            int a, b;
            a = int'(qh_log[(qs + i) % 64] - QHB) / 16;
            b = int'(qh_log[(qs + i + 1) % 64] - QHB) / 16;
            chk("R10 rotation order", b, (a + 1) % NUM_EP);
        end
        pop_check(3, 16'h0960, "R5 channel independence");
        pop_check(0, 16'h0900, "R5 channel independence");
        flush(4'b1111);
        chk("R8 flush all", ep_primed, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule